// File: doc/BRIEF.md
# Predicated Four-Way Deinterleaving Byte Loader

This block fetches a run of four-byte records from byte-addressed memory and splits them so that the bytes of each record land in the same element position of four different vector registers: byte r of record e becomes element e of destination register r. A command supplies a 64-bit base, a 64-bit index value, the number of the scalar register that held that index, a per-element predicate, and the number of the first destination register. The block reads bytes one at a time over a request/response memory port, collects the four result vectors internally, and then writes them into a 32-entry vector register file model.

A clear predicate bit suppresses all four memory reads of its record and forces that element to zero in all four destinations. The four destination register numbers wrap around the top of the register file. A command that names scalar register 31 as the index source is an illegal encoding and is refused outright. The register file has a registered read port, which is how its contents are observed.

Top module: `quad_deint_loader`

## Requirements
- R1: The byte for slot r of element e is read from address base + index + 4*e + r, computed in 64 bits and wrapping modulo 2^64.
- R2: Memory reads are issued in ascending element order, and within one element in ascending slot order 0, 1, 2, 3.
- R3: For an element whose predicate bit is 0, no read is issued for any of its four bytes, and bits [8e+7:8e] of all four destinations are written as zero.
- R4: For an element whose predicate bit is 1, the byte returned for slot r is written to bits [8e+7:8e] of destination r.
- R5: Destination r is register (dst + r) mod 32 for r = 0..3; no other register of the file changes.
- R6: A command whose index register number is 31 raises err for exactly one cycle and causes no memory request, no register write and no done.
- R7: A command with an all-zero predicate completes with done, issues no memory request, and leaves all four destinations zero.
- R8: At most one read is outstanding; a request keeps mem_req_valid high and mem_req_addr unchanged until mem_req_ready, and the block waits for the response before the next request.
- R9: No destination changes until all elements are processed; done is high for exactly one cycle, rising at the clock edge of the last of the four register writes.
- R10: After reset, cmd_ready is 1 and done, err and mem_req_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present; taken when cmd_ready is 1 |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_base | input | 64 | Base byte address |
| cmd_index | input | 64 | Index value added to the base |
| cmd_index_sel | input | 5 | Number of the register that held the index; 31 is illegal |
| cmd_pred | input | 16 | Predicate, one bit per element |
| cmd_dst | input | 5 | First destination register number |
| mem_req_valid | output | 1 | Byte read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Byte address of the request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Block waiting for read data |
| mem_rsp_data | input | 8 | Returned byte |
| rd_sel | input | 5 | Register file read address |
| rd_data | output | 128 | Register file read data, one cycle after rd_sel |
| done | output | 1 | One-cycle pulse when all four registers are written |
| err | output | 1 | One-cycle pulse when an illegal command is refused |

## Verification
The bench aims at the address arithmetic where base plus index crosses the 2^64 boundary, where a design that dropped carries or used a narrow adder would read the wrong bytes, and at sparse predicates where an implementation that fetched inactive records or left stale data in their lanes would show up as extra traffic or nonzero lanes. It places the destination at 30 so that a missing modulo would write the wrong register or disturb a neighbour, and it watches the last destination while the command runs so that an early commit is caught. It also sends index register 31 and an empty predicate, where a design that still touched memory or the register file, or forgot to finish, would be exposed.

// File: rtl/ldx4_pkg.sv
package ldx4_pkg;
  localparam int NSLOT = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_ADDR,
    ST_REQ,
    ST_WAIT,
    ST_COMMIT
  } ld_state_e;
endpackage

// File: rtl/ldx4_addr_gen.sv
module ldx4_addr_gen #(
  parameter int AW    = 64,
  parameter int EW    = 4,
  parameter int SW    = 2,
  parameter int NSLOT = 4
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] index,
  input  logic [EW-1:0] elem,
  input  logic [SW-1:0] slot,
  output logic [AW-1:0] addr
);
  // Record stride equals the slot count; all sums wrap at AW bits.
  always_comb begin
    addr = base + index + (AW'(elem) * AW'(NSLOT)) + AW'(slot);
  end
endmodule

// File: rtl/ldx4_slot_buf.sv
module ldx4_slot_buf #(
  parameter int VBYTES = 16,
  parameter int NSLOT  = 4,
  localparam int EW = $clog2(VBYTES),
  localparam int SW = $clog2(NSLOT),
  localparam int VW = VBYTES * 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       we,
  input  logic [SW-1:0]              slot,
  input  logic [EW-1:0]              elem,
  input  logic [7:0]                 din,
  output logic [NSLOT-1:0][VW-1:0]   dout
);
  // Clearing at command start makes inactive lanes zero with no write.
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        dout[s] <= '0;
      end else if (we && (slot == SW'(s))) begin
        dout[s][{elem, 3'b000} +: 8] <= din;
      end
    end
  end
endmodule

// File: rtl/ldx4_vrf.sv
module ldx4_vrf #(
  parameter int NREGS = 32,
  parameter int VW    = 128,
  localparam int RW = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] wa,
  input  logic [VW-1:0] wd,
  input  logic [RW-1:0] ra,
  output logic [VW-1:0] rd
);
  logic [VW-1:0] mem [NREGS];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end
endmodule

// File: rtl/quad_deint_loader.sv
module quad_deint_loader #(
  parameter int VBYTES = 16,
  parameter int AW     = 64,
  parameter int NREGS  = 32,
  localparam int NSLOT = ldx4_pkg::NSLOT,
  localparam int EW    = $clog2(VBYTES),
  localparam int SW    = $clog2(NSLOT),
  localparam int RW    = $clog2(NREGS),
  localparam int VW    = VBYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [AW-1:0]     cmd_base,
  input  logic [AW-1:0]     cmd_index,
  input  logic [RW-1:0]     cmd_index_sel,
  input  logic [VBYTES-1:0] cmd_pred,
  input  logic [RW-1:0]     cmd_dst,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [7:0]        mem_rsp_data,
  input  logic [RW-1:0]     rd_sel,
  output logic [VW-1:0]     rd_data,
  output logic              done,
  output logic              err
);
  import ldx4_pkg::*;

  localparam logic [RW-1:0] BAD_SEL   = '1;
  localparam logic [EW-1:0] ELEM_LAST = EW'(VBYTES - 1);
  localparam logic [SW-1:0] SLOT_LAST = SW'(NSLOT - 1);

  ld_state_e            state_q;
  logic [AW-1:0]        base_q, index_q, req_addr_q, gen_addr;
  logic [VBYTES-1:0]    pred_q;
  logic [RW-1:0]        dst_q;
  logic [EW-1:0]        e_q;
  logic [SW-1:0]        r_q, c_q;
  logic                 done_q, err_q;
  logic                 buf_clr, buf_we, vrf_we;
  logic [RW-1:0]        vrf_wa;
  logic [NSLOT-1:0][VW-1:0] slot_bufs;

  assign cmd_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_rsp_ready = (state_q == ST_WAIT);
  assign mem_req_addr  = req_addr_q;
  assign done          = done_q;
  assign err           = err_q;

  assign buf_clr = (state_q == ST_IDLE) && cmd_valid && (cmd_index_sel != BAD_SEL);
  assign buf_we  = (state_q == ST_WAIT) && mem_rsp_valid;
  assign vrf_we  = (state_q == ST_COMMIT);
  assign vrf_wa  = dst_q + RW'(c_q);

  ldx4_addr_gen #(.AW(AW), .EW(EW), .SW(SW), .NSLOT(NSLOT)) u_agen (
    .base  (base_q),
    .index (index_q),
    .elem  (e_q),
    .slot  (r_q),
    .addr  (gen_addr)
  );

  ldx4_slot_buf #(.VBYTES(VBYTES), .NSLOT(NSLOT)) u_buf (
    .clk  (clk),
    .rst  (rst),
    .clr  (buf_clr),
    .we   (buf_we),
    .slot (r_q),
    .elem (e_q),
    .din  (mem_rsp_data),
    .dout (slot_bufs)
  );

  ldx4_vrf #(.NREGS(NREGS), .VW(VW)) u_vrf (
    .clk (clk),
    .we  (vrf_we),
    .wa  (vrf_wa),
    .wd  (slot_bufs[c_q]),
    .ra  (rd_sel),
    .rd  (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      base_q     <= '0;
      index_q    <= '0;
      pred_q     <= '0;
      dst_q      <= '0;
      e_q        <= '0;
      r_q        <= '0;
      c_q        <= '0;
      req_addr_q <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            if (cmd_index_sel == BAD_SEL) begin
              err_q <= 1'b1;
            end else begin
              base_q  <= cmd_base;
              index_q <= cmd_index;
              pred_q  <= cmd_pred;
              dst_q   <= cmd_dst;
              e_q     <= '0;
              r_q     <= '0;
              c_q     <= '0;
              state_q <= ST_SCAN;
            end
          end
        end
        ST_SCAN: begin
          if (pred_q[e_q]) begin
            state_q <= ST_ADDR;
          end else if (e_q == ELEM_LAST) begin
            state_q <= ST_COMMIT;
          end else begin
            e_q <= e_q + 1'b1;
          end
        end
        ST_ADDR: begin
          req_addr_q <= gen_addr;
          state_q    <= ST_REQ;
        end
        ST_REQ: begin
          if (mem_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (r_q == SLOT_LAST) begin
              r_q <= '0;
              if (e_q == ELEM_LAST) begin
                state_q <= ST_COMMIT;
              end else begin
                e_q     <= e_q + 1'b1;
                state_q <= ST_SCAN;
              end
            end else begin
              r_q     <= r_q + 1'b1;
              state_q <= ST_ADDR;
            end
          end
        end
        ST_COMMIT: begin
          c_q <= c_q + 1'b1;
          if (c_q == SLOT_LAST) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Request held steady until the memory side takes it.
  p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // An accepted request is followed by waiting for its byte.
  p_rsp_follow_r8: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_req_ready |=> mem_rsp_ready && !mem_req_valid);

  // Never more than one of: idle, requesting, waiting, committing.
  p_single_act_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_req_valid, mem_rsp_ready, vrf_we, cmd_ready}));

  // Consecutive commit writes step the register number with wrap.
  p_commit_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    vrf_we && $past(vrf_we) |-> vrf_wa == RW'($past(vrf_wa) + 1'b1));

  // Done only right after a register file write.
  p_done_after_write_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(vrf_we) && !vrf_we);

  // A refused command causes no traffic, no write and no done.
  p_reject_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    err |-> !mem_req_valid && !vrf_we && !done);
endmodule

// File: tb/sim_quad_deint_loader.sv
module sim_quad_deint_loader;
  localparam int VB = 16;
  localparam int VW = VB * 8;

  typedef struct packed {
    logic [63:0] base;
    logic [63:0] idx;
    logic [15:0] mask;
    logic [4:0]  dst;
    logic [4:0]  sel;
  } vec_t;

  localparam vec_t VT [6] = '{
    '{64'h0000_0000_0000_1000, 64'h20,                  16'hFFFF, 5'd0,  5'd2},
    '{64'h0000_0000_0000_2000, 64'h0,                   16'hA5A5, 5'd4,  5'd30},
    '{64'hFFFF_FFFF_FFFF_FFF0, 64'h8,                   16'hFFFF, 5'd8,  5'd0},
    '{64'h0000_0000_0000_4000, 64'h4,                   16'h0000, 5'd12, 5'd5},
    '{64'h0000_0000_0000_0300, 64'h10,                  16'h8001, 5'd30, 5'd7},
    '{64'h0,                   64'hFFFF_FFFF_FFFF_FFFC, 16'h0002, 5'd3,  5'd1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [63:0] cmd_base = '0, cmd_index = '0;
  logic [4:0]  cmd_index_sel = '0, cmd_dst = '0;
  logic [15:0] cmd_pred = '0;
  logic mem_req_valid, mem_rsp_ready;
  logic mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [7:0] mem_rsp_data = '0;
  logic [4:0] rd_sel = '0;
  logic [VW-1:0] rd_data;
  logic done, err;

  always #2 clk = ~clk;

  quad_deint_loader u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_base(cmd_base), .cmd_index(cmd_index), .cmd_index_sel(cmd_index_sel),
    .cmd_pred(cmd_pred), .cmd_dst(cmd_dst),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .done(done), .err(err)
  );

  int n_tests = 0;
  int n_fail  = 0;

  function automatic logic [7:0] memf(logic [63:0] a);
    return (a[7:0] ^ 8'hA5) + a[15:8] + a[63:56];
  endfunction

  task automatic chk(bit ok, string req, string what, logic [VW-1:0] act, logic [VW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Memory model: logs every accepted request, answers with varying latency.
  logic [63:0] log_addr [64];
  int   log_n = 0;
  int   viol_n = 0;
  bit   seen_done = 1'b0;
  bit   pending = 1'b0;
  logic [63:0] pend_addr = '0;
  int   lat = 0;
  int   tick = 0;

  always @(negedge clk) begin
    tick++;
    if (done) seen_done = 1'b1;
    mem_rsp_valid = 1'b0;
    if (pending) begin
      if (lat == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = memf(pend_addr);
        if (mem_rsp_ready) pending = 1'b0;
      end else begin
        lat--;
      end
      if (mem_req_valid) viol_n++;
    end
    mem_req_ready = !pending && (tick % 3 != 2);
    if (mem_req_ready && mem_req_valid) begin
      if (log_n < 64) log_addr[log_n] = mem_req_addr;
      log_n++;
      pending   = 1'b1;
      pend_addr = mem_req_addr;
      lat       = tick % 3;
    end
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  logic [VW-1:0] shadow [32];
  bit            known  [32];

  task automatic read_reg(input logic [4:0] idx, output logic [VW-1:0] v);
    rd_sel = idx;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic run_cmd(vec_t v);
    logic [63:0]   exp_addr [64];
    int            exp_n;
    logic [VW-1:0] exp_vec [4];
    logic [VW-1:0] got;
    logic [4:0]    watch;
    bit            watch_ok;
    bit            order_ok;
    int            wait_n;
    exp_n = 0;
    for (int r = 0; r < 4; r++) exp_vec[r] = '0;
    for (int e = 0; e < VB; e++) begin
      if (v.mask[e]) begin
        for (int r = 0; r < 4; r++) begin
          logic [63:0] a;
          a = v.base + v.idx + 64'(4 * e) + 64'(r);
          exp_addr[exp_n] = a;
          exp_n++;
          exp_vec[r][8*e +: 8] = memf(a);
        end
      end
    end
    log_n = 0;
    viol_n = 0;
    watch = v.dst + 5'd3;
    rd_sel = watch;
    @(negedge clk);
    cmd_base = v.base; cmd_index = v.idx; cmd_pred = v.mask;
    cmd_dst = v.dst; cmd_index_sel = v.sel; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    watch_ok = 1'b1;
    wait_n = 0;
    while (!done && wait_n < 2000) begin
      if (known[watch] && rd_data !== shadow[watch]) watch_ok = 1'b0;
      @(negedge clk);
      wait_n++;
    end
    if (known[watch] && rd_data !== shadow[watch]) watch_ok = 1'b0;
    chk(done === 1'b1, "R9", "done reached", VW'(done), VW'(1));
    chk(watch_ok, "R9", "no register change before commit", VW'(watch_ok), VW'(1));
    @(negedge clk);
    chk(done === 1'b0, "R9", "done one cycle", VW'(done), VW'(0));
    chk(log_n == exp_n, (v.mask == 0) ? "R7" : "R3", "request count", VW'(log_n), VW'(exp_n));
    order_ok = 1'b1;
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (log_addr[i] !== exp_addr[i]) order_ok = 1'b0;
    chk(order_ok, "R1", "addresses in R2 order", VW'(log_n), VW'(exp_n));
    chk(viol_n == 0, "R8", "single outstanding", VW'(viol_n), VW'(0));
    for (int k = 4; k <= 31; k += 27) begin
      logic [4:0] nb;
      nb = v.dst + 5'(k);
      if (known[nb]) begin
        read_reg(nb, got);
        chk(got === shadow[nb], "R5", "neighbour untouched", got, shadow[nb]);
      end
    end
    for (int r = 0; r < 4; r++) begin
      logic [4:0] d;
      d = v.dst + 5'(r);
      shadow[d] = exp_vec[r];
      known[d]  = 1'b1;
      read_reg(d, got);
      chk(got === exp_vec[r], (v.mask == 16'hFFFF) ? "R4" : "R3", "destination", got, exp_vec[r]);
    end
  endtask

  initial begin
    logic [VW-1:0] got;
    for (int i = 0; i < 32; i++) begin shadow[i] = '0; known[i] = 1'b0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(cmd_ready === 1'b1, "R10", "cmd_ready", VW'(cmd_ready), VW'(1));
    chk(done === 1'b0, "R10", "done", VW'(done), VW'(0));
    chk(err === 1'b0, "R10", "err", VW'(err), VW'(0));
    chk(mem_req_valid === 1'b0, "R10", "mem_req_valid", VW'(mem_req_valid), VW'(0));

    // Table walk: R1..R5, R7..R9
    for (int i = 0; i < 6; i++) run_cmd(VT[i]);

    // R6: index register 31 refused
    log_n = 0;
    seen_done = 1'b0;
    cmd_base = 64'h5000; cmd_index = 64'h0; cmd_pred = 16'hFFFF;
    cmd_dst = 5'd0; cmd_index_sel = 5'd31; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(err === 1'b1, "R6", "err pulse", VW'(err), VW'(1));
    @(negedge clk);
    chk(err === 1'b0, "R6", "err one cycle", VW'(err), VW'(0));
    repeat (10) @(negedge clk);
    chk(log_n == 0, "R6", "no memory request", VW'(log_n), VW'(0));
    chk(!seen_done, "R6", "no done", VW'(seen_done), VW'(0));
    chk(cmd_ready === 1'b1, "R6", "still idle", VW'(cmd_ready), VW'(1));
    for (int r = 0; r < 4; r++) begin
      read_reg(5'(r), got);
      chk(got === shadow[r], "R6", "register unchanged", got, shadow[r]);
    end

    // After rejection a legal command still works (R4)
    run_cmd('{64'h7000, 64'h40, 16'hFFFF, 5'd20, 5'd3});

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule